// File: doc/BRIEF.md
# Multi-Granularity Rotate and Shift Datapath

This block is a combinational 32-bit datapath. It performs left or right rotations, and left or right logical shifts, on four independent bytes, on two independent 16-bit halves, or on the whole 32-bit word. The lane width is chosen at run time.

Every rotation starts in four 8-bit left-only barrel shifters. Two levels of per-bit lane-swap switches follow them and join neighbouring lanes into wider rotations. The first level pairs bytes 3/2 and bytes 1/0. The second level pairs the two 16-bit halves. A final AND layer clears the bit positions that a logical shift must fill with zero.

Every control bit arrives as a raw input, so an external decoder or a configuration memory supplies the per-shifter amounts, the switch states and the mask. The datapath has no clock and no state.

Top module: `mgran_rotshift`

## Requirements
- R1: Byte j is `data_i[8j+7:8j]`, and its amount is `amt_i[3j+2:3j]`, where bit 0 weighs 1, bit 1 weighs 2 and bit 2 weighs 4. With every switch in through (0) and every mask bit at 1, output byte j equals byte j rotated left by its amount.
- R2: A barrel amount of zero passes its byte unchanged.
- R3: Setting `sw1_i[8h+b]` to 1 (cross) exchanges bit b of rotated byte 2h+1 with bit b of rotated byte 2h, for h in 0..1. A 0 (through) leaves both bits in place.
- R4: Setting `sw2_i[p]` to 1 exchanges bit p of the upper 16-bit half with bit p of the lower half after the first switch level. A 0 leaves both bits in place.
- R5: A 16-bit pair rotates left by k, for 0 ≤ k < 8, when both of its bytes rotate by k and the pair's first-level controls for bit positions below k are 1.
- R6: A 16-bit pair rotates left by 8+k', for 0 ≤ k' < 8, when both of its bytes rotate by k' and the pair's first-level controls for bit positions k' and above are 1.
- R7: The full word rotates left by any k in 0..31. Both pairs are set up as in R5 or R6 for k mod 16. The second-level controls below k are set when k < 16. The controls at k−16 and above are set when k ≥ 16.
- R8: A right rotation by k of a lane of width W equals the left rotation by (W−k) mod W, set up as in R1, R5, R6 or R7.
- R9: Output bit i equals the switched bit i when `mask_i[i]` is 1, and is 0 otherwise. A logical left shift by k of a lane is the left rotation by k with the lane's low k mask bits at 0. A logical right shift by k is the right rotation by k with the lane's high k mask bits at 0.
- R10: The output follows input changes with no clock. With all controls at zero and the mask at all ones, the output equals the input.
- R11: With the mask at all ones, the output holds exactly as many 1 bits as the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Data word |
| amt_i | input | 12 | Left-rotate amount, 3 bits per byte shifter |
| sw1_i | input | 16 | First-level swap controls, bytes 3/2 (upper 8) and 1/0 (lower 8) |
| sw2_i | input | 16 | Second-level swap controls between the 16-bit halves |
| mask_i | input | 32 | AND mask, 0 clears the bit |
| data_o | output | 32 | Transformed word |

## Verification
The bench sweeps every amount at each lane width, in both directions and as both rotation and logical shift. It uses four data words: a sparse word with both end bits set, a half-filled word, an alternating word and an irregular word. Together they show whether a bit is lost at a lane seam, moved to the wrong lane or left unmasked. In the byte mode each lane gets a different amount, which exposes crossed amount wiring. Single-switch tests at every position of both levels, starting from an unrotated word, separate a wrong bit pairing from a wrong level.

// File: rtl/mgran_pkg.sv
package mgran_pkg;
  localparam int LANE_W_DEF = 8;
  localparam int NUM_LANES  = 4;
  localparam int NUM_PAIRS  = NUM_LANES / 2;
endpackage

// File: rtl/mgran_barrel.sv
module mgran_barrel #(
  parameter int W = mgran_pkg::LANE_W_DEF,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  lane_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  lane_o
);
  logic [SW:0][W-1:0] stage_w;
  assign stage_w[0] = lane_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage_w[s+1] = amt_i[s] ? {stage_w[s][W-1-SH:0], stage_w[s][W-1:W-SH]}
                                   : stage_w[s];
  end

  assign lane_o = stage_w[SW];

  always_comb begin
    if (!$isunknown({lane_i, amt_i})) begin
      AST_ROT_KEEPS_ONES: assert ($countones(lane_o) == $countones(lane_i))
        else $error("rotation changed ones count"); // R1
      if (amt_i == '0)
        AST_ROT_ZERO_PASS: assert (lane_o == lane_i)
          else $error("zero amount altered lane"); // R2
    end
  end
endmodule

// File: rtl/mgran_swap.sv
module mgran_swap #(
  parameter int W = 2 * mgran_pkg::LANE_W_DEF
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] cross_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign hi_o[b] = cross_i[b] ? lo_i[b] : hi_i[b];
    assign lo_o[b] = cross_i[b] ? hi_i[b] : lo_i[b];
  end

  always_comb begin
    if (!$isunknown({hi_i, lo_i, cross_i})) begin
      AST_SWAP_KEEPS_ONES: assert (($countones(hi_o) + $countones(lo_o)) ==
                                   ($countones(hi_i) + $countones(lo_i)))
        else $error("swap level lost bits"); // R3, R4
      if (cross_i == '0)
        AST_SWAP_THROUGH: assert (hi_o == hi_i && lo_o == lo_i)
          else $error("through state moved bits"); // R3, R4
    end
  end
endmodule

// File: rtl/mgran_mask.sv
module mgran_mask #(
  parameter int W = mgran_pkg::LANE_W_DEF,
  parameter int N = mgran_pkg::NUM_LANES
) (
  input  logic [N*W-1:0] word_i,
  input  logic [N*W-1:0] keep_i,
  output logic [N*W-1:0] word_o
);
  for (genvar j = 0; j < N; j++) begin : g_lane
    assign word_o[j*W +: W] = word_i[j*W +: W] & keep_i[j*W +: W];
  end
endmodule

// File: rtl/mgran_rotshift.sv
module mgran_rotshift #(
  parameter int LANE_W = mgran_pkg::LANE_W_DEF,
  localparam int AMT_W  = $clog2(LANE_W),
  localparam int NL     = mgran_pkg::NUM_LANES,
  localparam int NP     = mgran_pkg::NUM_PAIRS,
  localparam int WORD_W = NL * LANE_W,
  localparam int HALF_W = NP * LANE_W
) (
  input  logic [WORD_W-1:0]   data_i,
  input  logic [NL*AMT_W-1:0] amt_i,
  input  logic [HALF_W-1:0]   sw1_i,
  input  logic [HALF_W-1:0]   sw2_i,
  input  logic [WORD_W-1:0]   mask_i,
  output logic [WORD_W-1:0]   data_o
);
  logic [NL-1:0][LANE_W-1:0] rot_w;
  logic [NL-1:0][LANE_W-1:0] lvl1_w;
  logic [HALF_W-1:0]         lvl2_hi_w, lvl2_lo_w;
  logic [WORD_W-1:0]         swapped_w;

  for (genvar j = 0; j < NL; j++) begin : g_bs
    mgran_barrel #(.W(LANE_W)) u_bs (
      .lane_i (data_i[j*LANE_W +: LANE_W]),
      .amt_i  (amt_i[j*AMT_W +: AMT_W]),
      .lane_o (rot_w[j])
    );
  end

  for (genvar h = 0; h < NP; h++) begin : g_l1
    mgran_swap #(.W(LANE_W)) u_sw1 (
      .hi_i    (rot_w[2*h+1]),
      .lo_i    (rot_w[2*h]),
      .cross_i (sw1_i[h*LANE_W +: LANE_W]),
      .hi_o    (lvl1_w[2*h+1]),
      .lo_o    (lvl1_w[2*h])
    );
  end

  mgran_swap #(.W(HALF_W)) u_sw2 (
    .hi_i    ({lvl1_w[3], lvl1_w[2]}),
    .lo_i    ({lvl1_w[1], lvl1_w[0]}),
    .cross_i (sw2_i),
    .hi_o    (lvl2_hi_w),
    .lo_o    (lvl2_lo_w)
  );

  assign swapped_w = {lvl2_hi_w, lvl2_lo_w};

  mgran_mask #(.W(LANE_W), .N(NL)) u_mask (
    .word_i (swapped_w),
    .keep_i (mask_i),
    .word_o (data_o)
  );

  always_comb begin
    if (!$isunknown({data_i, amt_i, sw1_i, sw2_i, mask_i})) begin
      if (&mask_i)
        AST_ONES_KEPT: assert ($countones(data_o) == $countones(data_i))
          else $error("unmasked path changed ones count"); // R11
      if (&mask_i && amt_i == '0 && sw1_i == '0 && sw2_i == '0)
        AST_IDENTITY: assert (data_o == data_i)
          else $error("idle configuration altered data"); // R10
    end
  end
endmodule

// File: tb/mgran_rotshift_tb.sv
module mgran_rotshift_tb_top;
  logic        clk = 1'b0;
  logic [31:0] data, mask, dout;
  logic [11:0] amt;
  logic [15:0] sw1, sw2;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mgran_rotshift dut_i (
    .data_i(data), .amt_i(amt), .sw1_i(sw1), .sw2_i(sw2),
    .mask_i(mask), .data_o(dout)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input int w);
    logic [63:0] one = 64'd1;
    return 32'((one << w) - 1);
  endfunction

  // group rotate-left by l -> controls
  task automatic setup_group(input int gw, input int g, input int l);
    int l16, lb;
    l16 = l % 16;
    lb  = l % 8;
    if (gw == 8) amt[3*g +: 3] = 3'(l);
    else if (gw == 16) begin
      amt[6*g +: 3] = 3'(lb);
      amt[6*g+3 +: 3] = 3'(lb);
      for (int b = 0; b < 8; b++) sw1[8*g+b] = (l < 8) ? (b < l) : (b >= lb);
    end else begin
      for (int j = 0; j < 4; j++) amt[3*j +: 3] = 3'(lb);
      for (int h = 0; h < 2; h++)
        for (int b = 0; b < 8; b++) sw1[8*h+b] = (l16 < 8) ? (b < l16) : (b >= lb);
      for (int p = 0; p < 16; p++) sw2[p] = (l < 16) ? (p < l) : (p >= l16);
    end
  endtask

  task automatic run_case(input int gw, input int k, input bit left, input bit logical,
                          input logic [31:0] d);
    logic [31:0] exp, m;
    logic [63:0] x;
    int kk, l;
    string tag;
    amt = '0; sw1 = '0; sw2 = '0; mask = '1; data = d; exp = '0;
    m = lmask(gw);
    for (int g = 0; g < 32 / gw; g++) begin
      kk = (gw == 32) ? k : (k + 3 * g) % gw;
      l  = left ? kk : (gw - kk) % gw;
      setup_group(gw, g, l);
      x = 64'((d >> (g * gw)) & m);
      if (logical) begin
        if (left) begin
          for (int b = 0; b < kk; b++) mask[g*gw+b] = 1'b0;
          exp |= 32'(((x << kk) & 64'(m)) << (g * gw));
        end else begin
          for (int b = 0; b < kk; b++) mask[g*gw+gw-1-b] = 1'b0;
          exp |= 32'((x >> kk) << (g * gw));
        end
      end else if (left)
        exp |= 32'((((x << kk) | (x >> (gw - kk))) & 64'(m)) << (g * gw));
      else
        exp |= 32'((((x >> kk) | (x << (gw - kk))) & 64'(m)) << (g * gw));
    end
    #1;
    if (logical) tag = "R9";
    else if (!left) tag = "R8";
    else if (gw == 8) tag = "R1";
    else if (gw == 16) tag = "R5/R6";
    else tag = "R7";
    check($sformatf("%s gw=%0d k=%0d left=%0b", tag, gw, k, left), dout, exp);
  endtask

  initial begin
    logic [31:0] pats [4];
    logic [31:0] e;
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_0000;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h3C1E_87D2;

    // all-zero inputs give zero output (R10)
    data = '0; amt = '0; sw1 = '0; sw2 = '0; mask = '0;
    #1 check("R10 zero", dout, 32'h0);

    // idle config passes data, then follows a change with no clock edge (R10, R2)
    mask = '1; data = pats[3];
    #1 check("R2 idle pass", dout, pats[3]);
    data = pats[2];
    #1 check("R10 follow", dout, pats[2]);

    // single first-level switches (R3)
    for (int h = 0; h < 2; h++)
      for (int b = 0; b < 8; b++) begin
        data = pats[3]; amt = '0; sw2 = '0; mask = '1; sw1 = 16'(1) << (8 * h + b);
        e = data;
        e[16*h+8+b] = data[16*h+b];
        e[16*h+b]   = data[16*h+8+b];
        #1 check($sformatf("R3 h=%0d b=%0d", h, b), dout, e);
      end

    // single second-level switches (R4)
    for (int p = 0; p < 16; p++) begin
      data = pats[3]; amt = '0; sw1 = '0; mask = '1; sw2 = 16'(1) << p;
      e = data;
      e[16+p] = data[p];
      e[p]    = data[16+p];
      #1 check($sformatf("R4 p=%0d", p), dout, e);
    end

    // arbitrary mask on an unrotated word (R9)
    data = pats[3]; amt = '0; sw1 = '0; sw2 = '0; mask = 32'h0F0F_33CC;
    #1 check("R9 raw mask", dout, pats[3] & 32'h0F0F_33CC);

    // full sweep: every width, amount, direction, op, pattern (R1 R5 R6 R7 R8 R9)
    for (int gi = 0; gi < 3; gi++) begin
      int gw = 8 << gi;
      for (int k = 0; k < gw; k++)
        for (int dir = 0; dir < 2; dir++)
          for (int op = 0; op < 2; op++)
            for (int pi = 0; pi < 4; pi++)
              run_case(gw, k, dir[0], op[0], pats[pi]);
    end

    // ones count preserved when nothing is masked (R11)
    data = pats[3]; mask = '1; amt = 12'hB6D; sw1 = 16'h5A3C; sw2 = 16'hC381;
    #1 check("R11 ones", 32'($countones(dout)), 32'($countones(pats[3])));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule